// File: doc/BRIEF.md
# Double-Precision to Integer Converter

This block turns the bit pattern of an IEEE-754 binary64 value into an integer of one of four kinds: signed or unsigned, 32 or 64 bits wide. A rounding-mode input selects how fractions are resolved. A behaviour selector decides what happens to values that do not fit the target and to infinities and NaNs. The three behaviours are clamping with a NaN mapped to the target minimum, saturation with a NaN mapped to zero, and modular wrap in which non-finite inputs give zero. The result is always delivered as a 64-bit register value. A 32-bit target is reduced to its low 32 bits and then sign- or zero-extended.

Alongside the result the block reports five status bits: signalling-NaN invalid, conversion invalid, inexact, fraction-inexact and a summary bit. These are per-conversion values. Any sticky accumulation is done by the surrounding logic.

Operands enter on a valid/ready stream and leave on a second one after one register stage. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. When `out_valid` is high and `out_ready` is low, the output payload and `out_valid` hold unchanged and no new operand is accepted.

Top module: `fpi_conv`

## Requirements
- R1: `in_fmt` selects the target. Bit 0 set means unsigned and bit 1 set means 64-bit, so 0 = signed 32, 1 = unsigned 32, 2 = signed 64 and 3 = unsigned 64. The ranges are signed n-bit from -2^(n-1) to 2^(n-1)-1 and unsigned n-bit from 0 to 2^n-1.
- R2: With `in_mode` = 0 (clamp), or the unused code 3, a NaN gives the target minimum, and a rounded value above or below the range gives the target maximum or minimum respectively.
- R3: With `in_mode` = 1 (saturate), a NaN gives zero and out-of-range values clamp to the target maximum or minimum.
- R4: With `in_mode` = 2 (wrap), a finite input gives its rounded value modulo 2^64, further reduced per R6 for 32-bit targets, even when it is out of range. Infinities and NaNs give zero.
- R5: `in_rmode` selects rounding: 0 = to nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. In-range values are returned exactly as rounded.
- R6: For a 32-bit target the low 32 bits of the value are kept. For a signed target bit 31 is copied into bits 63:32, and for an unsigned target bits 63:32 are zero.
- R7: `out_inv_snan` is set exactly when the input is a NaN whose most significant fraction bit (bit 51) is clear.
- R8: `out_inv_cvt` is set exactly when the input is infinite or NaN, or its rounded value lies outside the target range.
- R9: `out_inexact` and `out_frac_inexact` are both set exactly when `out_inv_cvt` is clear and the rounded value differs from the input.
- R10: `out_summary` is set exactly when any of `out_inv_snan`, `out_inv_cvt` or `out_inexact` is set.
- R11: An accepted operand appears at the output on the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output payload is stable.
- R12: While `rst_n` is low, `out_valid` is cleared on the clock edge.
- R13: Subnormal inputs are treated as magnitudes below one and rounded like any other fraction, so the smallest positive subnormal gives 1 when rounding toward +infinity and 0 in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_bits | input | 64 | binary64 bit pattern |
| in_fmt | input | 2 | Target integer kind (R1) |
| in_mode | input | 2 | Out-of-range and NaN behaviour (R2 to R4) |
| in_rmode | input | 2 | Rounding mode (R5) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Converted integer |
| out_inv_snan | output | 1 | Signalling NaN seen |
| out_inv_cvt | output | 1 | Conversion invalid |
| out_inexact | output | 1 | Result inexact |
| out_frac_inexact | output | 1 | Fraction lost in rounding |
| out_summary | output | 1 | Any exception above |

## Verification
Rounding and range checking can act in the same cycle. An input just inside a bound can be carried across it by the rounding increment, such as 2147483647.5 or 4294967295.4 toward a 32-bit target. In that case the conversion must be reported invalid and must be clamped, wrapped or zeroed as the mode says, and it must not be reported inexact. The sweep drives such edge values under every rounding mode, target kind and behaviour, and compares against a model that rounds in real arithmetic and compares the rounded value with the bounds. A further case has stream acceptance and drain fall on one edge: the output is held under back-pressure, and then a new operand is taken on the edge that releases the old one.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  localparam int EXP_W    = 11;
  localparam int MAN_W    = 52;
  localparam int INT_W    = 64;
  localparam int NARROW_W = 32;

  typedef enum logic [1:0] {
    MODE_CLAMP = 2'd0,
    MODE_SAT   = 2'd1,
    MODE_WRAP  = 2'd2,
    MODE_SPARE = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_ZERO      = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;

  typedef struct packed {
    logic inv_snan;
    logic inv_cvt;
    logic inexact;
    logic frac_inx;
    logic summary;
  } flags_t;
endpackage

// File: rtl/fpi_unpack.sv
module fpi_unpack #(
  parameter int EXP_W = fpi_pkg::EXP_W,
  parameter int MAN_W = fpi_pkg::MAN_W,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0]  bits,
  output logic             sign,
  output logic             is_nan,
  output logic             is_inf,
  output logic             is_snan,
  output logic [EXP_W-1:0] exp_eff,
  output logic [MAN_W:0]   sig
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac;
  logic             exp_max, exp_zero, frac_nz;

  always_comb begin
    sign     = bits[FP_W-1];
    exp_f    = bits[FP_W-2 -: EXP_W];
    frac     = bits[MAN_W-1:0];
    exp_max  = &exp_f;
    exp_zero = ~|exp_f;
    frac_nz  = |frac;
    // subnormals share the scale of the smallest normal, hidden bit clear
    exp_eff  = exp_zero ? EXP_W'(1) : exp_f;
    sig      = {~exp_zero, frac};
    is_nan   = exp_max & frac_nz;
    is_inf   = exp_max & ~frac_nz;
    is_snan  = is_nan & ~frac[MAN_W-1];
  end
endmodule

// File: rtl/fpi_round.sv
module fpi_round
  import fpi_pkg::*;
#(
  parameter int EXP_W = fpi_pkg::EXP_W,
  parameter int MAN_W = fpi_pkg::MAN_W,
  parameter int INT_W = fpi_pkg::INT_W,
  localparam int SIG_W   = MAN_W + 1,
  localparam int SW      = EXP_W + 2,
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1,
  localparam int SHIFT0  = BIAS + MAN_W,
  localparam int HUGE_AT = INT_W - MAN_W
) (
  input  logic             sign,
  input  logic [EXP_W-1:0] exp_eff,
  input  logic [MAN_W:0]   sig,
  input  logic [1:0]       rmode,
  output logic [INT_W-1:0] lo,
  output logic             huge,
  output logic             inexact
);
  logic [SW-1:0]    sexp, rs, rsm1;
  logic             left;
  logic [SIG_W-1:0] int_part, below;
  logic             guard, sticky, inc;
  logic [SIG_W:0]   rounded;
  logic [INT_W-1:0] lsh;

  always_comb begin
    // scale of the significand's lsb, two's complement
    sexp  = {2'b00, exp_eff} - SW'(SHIFT0);
    left  = ~sexp[SW-1];
    rs    = SW'(0) - sexp;
    rsm1  = rs - SW'(1);

    int_part = sig >> rs;
    guard    = (rsm1 < SW'(SIG_W)) ? |(sig & (SIG_W'(1) << rsm1)) : 1'b0;
    below    = (rsm1 >= SW'(SIG_W)) ? {SIG_W{1'b1}}
                                    : ((SIG_W'(1) << rsm1) - SIG_W'(1));
    sticky   = |(sig & below);

    inc = 1'b0;
    case (rmode_e'(rmode))
      RM_NEAR_EVEN: inc = guard & (sticky | int_part[0]);
      RM_ZERO:      inc = 1'b0;
      RM_UP:        inc = (guard | sticky) & ~sign;
      RM_DOWN:      inc = (guard | sticky) & sign;
      default:      inc = 1'b0;
    endcase
    rounded = {1'b0, int_part} + {{SIG_W{1'b0}}, inc};

    // integral inputs: keep the low INT_W bits of the exact value
    lsh = (sexp < SW'(INT_W)) ? ({{(INT_W-SIG_W){1'b0}}, sig} << sexp) : '0;

    huge    = left & (sexp >= SW'(HUGE_AT));
    lo      = left ? lsh : {{(INT_W-SIG_W-1){1'b0}}, rounded};
    inexact = ~left & (guard | sticky);
  end
endmodule

// File: rtl/fpi_select.sv
module fpi_select
  import fpi_pkg::*;
#(
  parameter int INT_W    = fpi_pkg::INT_W,
  parameter int NARROW_W = fpi_pkg::NARROW_W,
  localparam int MW = INT_W + 1
) (
  input  logic             sign,
  input  logic             is_nan,
  input  logic             is_inf,
  input  logic             is_snan,
  input  logic             huge,
  input  logic             inexact,
  input  logic [INT_W-1:0] lo,
  input  logic [1:0]       fmt,
  input  logic [1:0]       mode,
  output logic [INT_W-1:0] result,
  output flags_t           flags
);
  logic          narrow, uns, nonfin, in_rng;
  logic [MW-1:0] span, half, pos_lim, neg_lim, mag;
  logic [INT_W-1:0] max_v, min_v, sval, raw;

  always_comb begin
    narrow  = ~fmt[1];
    uns     = fmt[0];
    span    = narrow ? (MW'(1) << NARROW_W) : (MW'(1) << INT_W);
    half    = span >> 1;
    pos_lim = uns ? span - MW'(1) : half - MW'(1);
    neg_lim = uns ? '0 : half;
    mag     = {1'b0, lo};
    nonfin  = is_nan | is_inf;
    in_rng  = ~nonfin & ~huge & (sign ? (mag <= neg_lim) : (mag <= pos_lim));

    max_v = pos_lim[INT_W-1:0];
    min_v = uns ? '0 : (~neg_lim[INT_W-1:0] + INT_W'(1));
    sval  = sign ? (~lo + INT_W'(1)) : lo;

    if (in_rng) raw = sval;
    else begin
      case (mode_e'(mode))
        MODE_SAT:  raw = is_nan ? '0 : (sign ? min_v : max_v);
        MODE_WRAP: raw = nonfin ? '0 : sval;
        default:   raw = is_nan ? min_v : (sign ? min_v : max_v);
      endcase
    end

    if (narrow)
      result = {{(INT_W-NARROW_W){~uns & raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
    else
      result = raw;

    flags.inv_snan = is_snan;
    flags.inv_cvt  = ~in_rng;
    flags.inexact  = in_rng & inexact;
    flags.frac_inx = in_rng & inexact;
    flags.summary  = is_snan | ~in_rng | inexact;
  end
endmodule

// File: rtl/fpi_conv.sv
module fpi_conv
  import fpi_pkg::*;
#(
  parameter int EXP_W    = fpi_pkg::EXP_W,
  parameter int MAN_W    = fpi_pkg::MAN_W,
  parameter int INT_W    = fpi_pkg::INT_W,
  parameter int NARROW_W = fpi_pkg::NARROW_W,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_bits,
  input  logic [1:0]       in_fmt,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_result,
  output logic             out_inv_snan,
  output logic             out_inv_cvt,
  output logic             out_inexact,
  output logic             out_frac_inexact,
  output logic             out_summary
);
  logic             sign, is_nan, is_inf, is_snan, huge, inexact, accept;
  logic [EXP_W-1:0] exp_eff;
  logic [MAN_W:0]   sig;
  logic [INT_W-1:0] lo, res_c, res_q;
  flags_t           flags_c, flags_q;

  fpi_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .bits(in_bits), .sign(sign), .is_nan(is_nan), .is_inf(is_inf),
    .is_snan(is_snan), .exp_eff(exp_eff), .sig(sig)
  );

  fpi_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_round (
    .sign(sign), .exp_eff(exp_eff), .sig(sig), .rmode(in_rmode),
    .lo(lo), .huge(huge), .inexact(inexact)
  );

  fpi_select #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_select (
    .sign(sign), .is_nan(is_nan), .is_inf(is_inf), .is_snan(is_snan),
    .huge(huge), .inexact(inexact), .lo(lo), .fmt(in_fmt), .mode(in_mode),
    .result(res_c), .flags(flags_c)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      flags_q   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_q     <= res_c;
      flags_q   <= flags_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_result       = res_q;
  assign out_inv_snan     = flags_q.inv_snan;
  assign out_inv_cvt      = flags_q.inv_cvt;
  assign out_inexact      = flags_q.inexact;
  assign out_frac_inexact = flags_q.frac_inx;
  assign out_summary      = flags_q.summary;
endmodule

// File: rtl/fpi_conv_chk.sv
module fpi_conv_chk #(
  parameter int FP_W     = 64,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [FP_W-1:0]  in_bits,
  input logic [1:0]       in_fmt,
  input logic [1:0]       in_mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [INT_W-1:0] out_result,
  input logic             out_inv_snan,
  input logic             out_inv_cvt,
  input logic             out_inexact,
  input logic             out_frac_inexact,
  input logic             out_summary
);
  logic take, nonfinite_in, nan_in;
  assign take         = in_valid & in_ready;
  assign nonfinite_in = &in_bits[FP_W-2 -: 11];
  assign nan_in       = nonfinite_in & |in_bits[FP_W-13:0];

  // R12
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R11
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R11
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R11
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_inv_cvt) && $stable(out_inexact));

  // R9
  inexact_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inexact |-> out_frac_inexact && out_summary && !out_inv_cvt);

  // R7
  snan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv_snan |-> out_inv_cvt && out_summary);

  // R6
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_fmt == 2'd0 |=>
      out_result[INT_W-1:NARROW_W] == {(INT_W-NARROW_W){out_result[NARROW_W-1]}});

  // R6
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_fmt == 2'd1 |=> out_result[INT_W-1:NARROW_W] == '0);

  // R4
  wrap_nonfinite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'd2 && nonfinite_in |=> out_result == '0);

  // R2
  clamp_nan_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'd0 && in_fmt == 2'd2 && nan_in |=>
      out_result == {1'b1, {(INT_W-1){1'b0}}});
endmodule

bind fpi_conv fpi_conv_chk #(.FP_W(FP_W), .INT_W(INT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bits(in_bits), .in_fmt(in_fmt), .in_mode(in_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_inv_snan(out_inv_snan), .out_inv_cvt(out_inv_cvt),
  .out_inexact(out_inexact), .out_frac_inexact(out_frac_inexact),
  .out_summary(out_summary)
);

// File: tb/fpi_conv_tb.sv
module fpi_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam real P31 = 2147483648.0;
  localparam real P32 = 4294967296.0;
  localparam real P63 = 9223372036854775808.0;
  localparam real P64 = 18446744073709551616.0;
  localparam int NVEC = 37;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [63:0] in_bits = '0;
  logic [1:0] in_fmt = '0, in_mode = '0, in_rmode = '0;
  logic [63:0] out_result;
  logic out_inv_snan, out_inv_cvt, out_inexact, out_frac_inexact, out_summary;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  fpi_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_fmt(in_fmt), .in_mode(in_mode), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_inv_snan(out_inv_snan), .out_inv_cvt(out_inv_cvt),
    .out_inexact(out_inexact), .out_frac_inexact(out_frac_inexact),
    .out_summary(out_summary)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] vecs [NVEC] = '{
    64'h0000000000000000, 64'h8000000000000000, 64'h3FE0000000000000,
    64'h3FF8000000000000, 64'h4004000000000000, 64'hC004000000000000,
    64'h3FE6666666666666, 64'hBFD3333333333333, 64'hBFE6666666666666,
    64'h400E000000000000, 64'hBFF0000000000000, 64'h41DFFFFFFFE00000,
    64'hC1E0000000100000, 64'h41E0000000000000, 64'hC1E0000000000000,
    64'h41F0000000000000, 64'h41EFFFFFFFE00000, 64'h41F0000000080000,
    64'h43E0000000000000, 64'hC3E0000000000000, 64'hC3E0000000000001,
    64'h43F0000000000000, 64'h43EFFFFFFFFFFFFF, 64'h4415AF1D78B58C40,
    64'hC1F2A05F20000000, 64'h7E37E43C8800759C, 64'h4450000000000001,
    64'h432FFFFFFFFFFFFF, 64'h0000000000000001, 64'h8000000000000001,
    64'h000FFFFFFFFFFFFF, 64'h7FF0000000000000, 64'hFFF0000000000000,
    64'h7FF8000000000000, 64'h7FF0000000000001, 64'hFFF4000000000000,
    64'hFFF8000000000001
  };

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      finish_run();
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic real round_real(input real x, input logic [1:0] rm);
    real f, d;
    case (rm)
      2'd0: begin
        f = $floor(x); d = x - f;
        if (d > 0.5) return f + 1.0;
        else if (d < 0.5) return f;
        else return (f - 2.0 * $floor(f / 2.0) == 0.0) ? f : f + 1.0;
      end
      2'd1: return (x >= 0.0) ? $floor(x) : $ceil(x);
      2'd2: return $ceil(x);
      default: return $floor(x);
    endcase
  endfunction

  // low 64 bits of the two's complement of an integral real
  function automatic logic [63:0] low_bits(input real ri);
    real a, m;
    logic [63:0] v;
    a = (ri < 0.0) ? -ri : ri;
    m = a - $floor(a / P64) * P64;
    v = (m >= P63) ? 64'(longint'(m - P64)) : 64'(longint'(m));
    return (ri < 0.0) ? (~v + 64'd1) : v;
  endfunction

  task automatic model(input logic [63:0] b, input logic [1:0] ft,
                       input logic [1:0] md, input logic [1:0] rm,
                       output logic [63:0] res, output logic [4:0] fl);
    logic nan, inf, snan, uns, nar, inv, inx, neg;
    real x, ri, hi, lo;
    logic [63:0] maxb, minb, w;
    nan  = (&b[62:52]) && (|b[51:0]);
    inf  = (&b[62:52]) && !(|b[51:0]);
    snan = nan && !b[51];
    neg  = b[63];
    nar  = !ft[1];
    uns  = ft[0];
    hi   = nar ? (uns ? P32 : P31) : (uns ? P64 : P63);
    lo   = uns ? 0.0 : (nar ? -P31 : -P63);
    maxb = nar ? (uns ? 64'h00000000FFFFFFFF : 64'h000000007FFFFFFF)
               : (uns ? 64'hFFFFFFFFFFFFFFFF : 64'h7FFFFFFFFFFFFFFF);
    minb = uns ? 64'd0 : (nar ? 64'hFFFFFFFF80000000 : 64'h8000000000000000);
    if (nan || inf) begin
      inv = 1'b1; inx = 1'b0; w = '0;
    end else begin
      x   = $bitstoreal(b);
      ri  = round_real(x, rm);
      inv = (ri >= hi) || (ri < lo);
      inx = !inv && (ri != x);
      w   = low_bits(ri);
    end
    if (!inv) res = w;
    else if (md == 2'd1) res = nan ? 64'd0 : (neg ? minb : maxb);
    else if (md == 2'd2) res = (nan || inf) ? 64'd0 : w;
    else res = nan ? minb : (neg ? minb : maxb);
    if (nar) res = uns ? {32'd0, res[31:0]} : {{32{res[31]}}, res[31:0]};
    fl = {snan, inv, inx, inx, snan | inv | inx};
  endtask

  // drive one operand, return the registered outputs one edge later
  task automatic apply(input logic [63:0] b, input logic [1:0] ft,
                       input logic [1:0] md, input logic [1:0] rm);
    @(negedge clk);
    in_bits = b; in_fmt = ft; in_mode = md; in_rmode = rm;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_and_compare(input logic [63:0] b, input logic [1:0] ft,
                                 input logic [1:0] md, input logic [1:0] rm);
    logic [63:0] er;
    logic [4:0] ef;
    string rtag;
    apply(b, ft, md, rm);
    model(b, ft, md, rm, er, ef);
    rtag = (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : "R2";
    check(rtag, $sformatf("result b=%h f=%0d m=%0d r=%0d", b, ft, md, rm), out_result, er);
    check("R7", "inv_snan", {63'd0, out_inv_snan}, {63'd0, ef[4]});
    check("R8", "inv_cvt", {63'd0, out_inv_cvt}, {63'd0, ef[3]});
    check("R9", "inexact pair", {62'd0, out_inexact, out_frac_inexact}, {62'd0, ef[2:1]});
    check("R10", "summary", {63'd0, out_summary}, {63'd0, ef[0]});
  endtask

  task automatic directed(input string tag, input logic [63:0] b, input logic [1:0] ft,
                          input logic [1:0] md, input logic [1:0] rm,
                          input logic [63:0] exp_res, input logic exp_inv, input logic exp_inx);
    apply(b, ft, md, rm);
    check(tag, $sformatf("directed result b=%h", b), out_result, exp_res);
    check(tag, "directed inv_cvt", {63'd0, out_inv_cvt}, {63'd0, exp_inv});
    check(tag, "directed inexact", {63'd0, out_inexact}, {63'd0, exp_inx});
  endtask

  logic [63:0] lfsr = 64'hACE1_2468_1357_9BDF;
  logic [63:0] held;

  initial begin
    repeat (3) @(negedge clk);
    // R12: idle after reset
    check("R12", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R11", "in_ready when empty", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    // R5: ties and directions on 2.5 and -2.5, signed 64
    directed("R5", 64'h4004000000000000, 2'd2, 2'd0, 2'd0, 64'd2, 1'b0, 1'b1);
    directed("R5", 64'h4004000000000000, 2'd2, 2'd0, 2'd1, 64'd2, 1'b0, 1'b1);
    directed("R5", 64'h4004000000000000, 2'd2, 2'd0, 2'd2, 64'd3, 1'b0, 1'b1);
    directed("R5", 64'hC004000000000000, 2'd2, 2'd0, 2'd3, -64'sd3, 1'b0, 1'b1);
    directed("R5", 64'hC004000000000000, 2'd2, 2'd0, 2'd0, -64'sd2, 1'b0, 1'b1);
    // R13: smallest subnormal
    directed("R13", 64'h0000000000000001, 2'd3, 2'd0, 2'd2, 64'd1, 1'b0, 1'b1);
    directed("R13", 64'h0000000000000001, 2'd3, 2'd0, 2'd0, 64'd0, 1'b0, 1'b1);
    directed("R13", 64'h8000000000000001, 2'd0, 2'd0, 2'd3, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1);
    // R1: target kinds and bounds
    directed("R1", 64'hBFF0000000000000, 2'd1, 2'd0, 2'd1, 64'd0, 1'b1, 1'b0);
    directed("R1", 64'h41EFFFFFFFE00000, 2'd1, 2'd0, 2'd1, 64'h00000000FFFFFFFF, 1'b0, 1'b0);
    directed("R1", 64'h41E0000000000000, 2'd0, 2'd0, 2'd1, 64'h000000007FFFFFFF, 1'b1, 1'b0);
    // R6: narrow signed sign extension
    directed("R6", 64'hBFF0000000000000, 2'd0, 2'd0, 2'd1, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0);
    // R4: wrap of 2^70 + 2^18 into 32 bits
    directed("R4", 64'h4450000000000001, 2'd1, 2'd2, 2'd0, 64'h0000000000040000, 1'b1, 1'b0);
    // R2 and R3: NaN handling
    directed("R2", 64'h7FF8000000000000, 2'd0, 2'd0, 2'd0, 64'hFFFFFFFF80000000, 1'b1, 1'b0);
    directed("R3", 64'h7FF8000000000000, 2'd0, 2'd1, 2'd0, 64'd0, 1'b1, 1'b0);

    // R11: back-pressure, then accept and drain on one edge
    @(negedge clk); out_ready = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    in_bits = 64'h400E000000000000; in_fmt = 2'd2; in_mode = 2'd0; in_rmode = 2'd1;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    held = out_result;
    check("R11", "first result", out_result, 64'd3);
    in_bits = 64'hC004000000000000; in_rmode = 2'd3;
    for (int k = 0; k < 3; k++) begin
      check("R11", "valid held", {63'd0, out_valid}, 64'd1);
      check("R11", "ready low when full", {63'd0, in_ready}, 64'd0);
      check("R11", "payload stable", out_result, held);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", "second result after release", out_result, -64'sd3);
    check("R11", "valid after swap", {63'd0, out_valid}, 64'd1);

    // sweep: edge vectors under every control combination
    for (int v = 0; v < NVEC; v++)
      for (int c = 0; c < 64; c++)
        run_and_compare(vecs[v], c[5:4], c[3:2], c[1:0]);

    // sweep: pseudo-random exponents around the integer boundaries
    for (int i = 0; i < 250; i++) begin
      logic [63:0] b;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      b = {lfsr[63], 11'(11'd990 + {4'd0, lfsr[58:52]}), lfsr[51:0]};
      for (int c = 0; c < 64; c++)
        run_and_compare(b, c[5:4], c[3:2], c[1:0]);
    end

    done = 1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule